// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer driven by one 32-bit control word. Two 2-bit codes set the timeout: a prescaler code picks how many clock cycles make one tick, and an interval code picks how many ticks make one interval. Each step of the interval code makes the interval four times longer. Software keeps the timer alive by writing the restart bit. A ping is usually a read-modify-write of the control word with that bit set.

When the interval runs out, the block sets a sticky warning flag. If the warning interrupt is enabled, that flag drives the interrupt output. Counting then goes on for a fixed grace period of ticks. If no restart arrives in that time and the reset-enable bit is set, the block sends a one-cycle reset request and sets a sticky reset flag. Writing zero to the whole word stops the timer. Writing the run, reset-enable and restart bits with the interrupt disabled arms the timer for a forced system reset.

Top module: `prewarn_wdog`

## Requirements
- R1: After reset, the control word reads 0x00000000, and the interrupt and reset-request outputs are low.
- R2: A written control word reads back with bits 11:10 (prescaler code), 7 (run), 6 (warning-interrupt enable), 5:4 (interval code) and 1 (reset enable) as written. Bit 0 (restart) always reads 0. Bits 31:12, 9 and 8 read 0.
- R3: With run set, the warning flag (bit 3) sets exactly DIV[p] × 2^(SPAN_LOG0 + 2·i) clock cycles after the write edge that started counting. Here p is the prescaler code and i is the interval code.
- R4: The interrupt output is high exactly when both the warning flag and the enable in bit 6 are set. The flag still sets when bit 6 is clear.
- R5: Writing 1 to bit 0 clears the count. The next expiry then falls a full timeout after that write edge.
- R6: If bit 1 is set, a one-cycle reset request comes GRACE × DIV[p] cycles after expiry and sets the reset flag (bit 2). No further request follows until the timer is restarted. If bit 1 is clear, there is no request and bit 2 stays 0.
- R7: The flags are write-one-to-clear. Writing 1 to bit 3 clears the warning flag and drops the interrupt output.
- R8: Writing zero to the whole word stops counting. Bit 7 then reads 0 and no expiry occurs, however long the timer is left.
- R9: A write that changes the prescaler or interval code while running clears the count, even without the restart bit. The new timeout is measured from that write edge.
- R10: Writing run, reset enable and restart with the warning interrupt disabled gives a reset request after the full timeout plus the grace period. The interrupt output stays low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Current control word and flags |
| irq | output | 1 | Warning interrupt (flag AND enable) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Each write takes effect at the clock edge that samples it. The warning flag and the interrupt rise exactly DIV × interval cycles after that edge. The reset request is high for the single cycle that begins DIV × GRACE cycles later. Each scenario task counts falling edges from the write edge. It checks that the output is still low one cycle before it is due, high in the cycle it is due, and, for the reset request, low again one cycle after. The bench uses small prescaler, interval and grace parameters, so every code combination, including the longest, fits within a few thousand cycles.

// File: rtl/prewarn_wdog_pkg.sv
package prewarn_wdog_pkg;

    // Bit positions of the control word (software decodes these)
    localparam int unsigned B_RESTART = 0;
    localparam int unsigned B_RST_EN  = 1;
    localparam int unsigned B_RST_FLG = 2;
    localparam int unsigned B_IRQ_FLG = 3;
    localparam int unsigned B_SPAN_LO = 4;
    localparam int unsigned B_IRQ_EN  = 6;
    localparam int unsigned B_RUN     = 7;
    localparam int unsigned B_DIV_LO  = 10;

    typedef struct packed {
        logic [1:0] div_sel;
        logic       run;
        logic       irq_en;
        logic [1:0] span_sel;
        logic       rst_en;
    } ctl_t;

    typedef enum logic [1:0] {
        PH_COUNT = 2'd0,
        PH_GRACE = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic ctl_t decode_ctl(input logic [31:0] w);
        ctl_t c;
        c.div_sel  = w[B_DIV_LO +: 2];
        c.run      = w[B_RUN];
        c.irq_en   = w[B_IRQ_EN];
        c.span_sel = w[B_SPAN_LO +: 2];
        c.rst_en   = w[B_RST_EN];
        return c;
    endfunction

    function automatic logic [31:0] encode_word(input ctl_t c, input logic irq_f,
                                                input logic rst_f);
        logic [31:0] w;
        w = '0;
        w[B_DIV_LO +: 2]  = c.div_sel;
        w[B_RUN]          = c.run;
        w[B_IRQ_EN]       = c.irq_en;
        w[B_SPAN_LO +: 2] = c.span_sel;
        w[B_IRQ_FLG]      = irq_f;
        w[B_RST_FLG]      = rst_f;
        w[B_RST_EN]       = c.rst_en;
        return w;
    endfunction

endpackage

// File: rtl/prewarn_wdog_prescaler.sv
module prewarn_wdog_prescaler #(
    parameter int unsigned DIV_0 = 1,
    parameter int unsigned DIV_1 = 256,
    parameter int unsigned DIV_2 = 2048,
    parameter int unsigned DIV_3 = 65536
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       clr_i,
    input  logic [1:0] div_sel_i,
    output logic       tick_o
);
    import prewarn_wdog_pkg::*;

    localparam int unsigned DIV_MAX = max_u(max_u(DIV_0, DIV_1), max_u(DIV_2, DIV_3));
    localparam int unsigned PW      = $clog2(DIV_MAX) + 1;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] last;

    always_comb begin
        unique case (div_sel_i)
            2'd0:    last = PW'(DIV_0 - 1);
            2'd1:    last = PW'(DIV_1 - 1);
            2'd2:    last = PW'(DIV_2 - 1);
            default: last = PW'(DIV_3 - 1);
        endcase
    end

    assign tick_o = en_i && !clr_i && (pre_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr_i || !en_i || tick_o)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // R8: a stopped timer holds its prescaler at zero
    a_r8_idle_prescaler: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (pre_q == '0));

endmodule

// File: rtl/prewarn_wdog_interval.sv
module prewarn_wdog_interval #(
    parameter int unsigned SPAN_LOG0 = 14,
    parameter int unsigned GRACE     = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       clr_i,
    input  logic [1:0] span_sel_i,
    input  logic       tick_i,
    output logic       expire_o,
    output logic       bite_o
);
    import prewarn_wdog_pkg::*;

    // longest interval is 2^(SPAN_LOG0+6) ticks
    localparam int unsigned CW = max_u(SPAN_LOG0 + 7, $clog2(GRACE) + 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] span_last;
    logic [5:0]    shamt;
    logic          live;

    assign shamt     = 6'(SPAN_LOG0) + {3'b000, span_sel_i, 1'b0};
    assign span_last = ({{(CW-1){1'b0}}, 1'b1} << shamt) - 1'b1;
    assign live      = en_i && !clr_i && tick_i;

    assign expire_o = live && (phase_q == PH_COUNT) && (cnt_q == span_last);
    assign bite_o   = live && (phase_q == PH_GRACE) && (cnt_q == CW'(GRACE - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i || !en_i) begin
            cnt_q   <= '0;
            phase_q <= PH_COUNT;
        end else if (expire_o) begin
            cnt_q   <= '0;
            phase_q <= PH_GRACE;
        end else if (bite_o) begin
            cnt_q   <= '0;
            phase_q <= PH_HOLD;
        end else if (tick_i && phase_q != PH_HOLD) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R5: a restart or code change rewinds the count to the start of an interval
    a_r5_clear_rewinds: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0 && phase_q == PH_COUNT));

    // R6: once the request has gone out, the count stays parked
    a_r6_hold_parked: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD && !clr_i && en_i) |=> (phase_q == PH_HOLD));

endmodule

// File: rtl/prewarn_wdog.sv
module prewarn_wdog #(
    parameter int unsigned DIV_0     = 1,
    parameter int unsigned DIV_1     = 256,
    parameter int unsigned DIV_2     = 2048,
    parameter int unsigned DIV_3     = 65536,
    parameter int unsigned SPAN_LOG0 = 14,
    parameter int unsigned GRACE     = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        rst_req
);
    import prewarn_wdog_pkg::*;

    ctl_t ctl_q;
    ctl_t ctl_w;
    logic irq_flag_q;
    logic rst_flag_q;
    logic clr;
    logic tick;
    logic expire;
    logic bite;

    assign ctl_w = decode_ctl(wr_data);

    // Any restart, stop, or code change rewinds the count
    assign clr = wr_en && (wr_data[B_RESTART] || !ctl_w.run ||
                           ctl_w.div_sel != ctl_q.div_sel ||
                           ctl_w.span_sel != ctl_q.span_sel);

    prewarn_wdog_prescaler #(
        .DIV_0(DIV_0), .DIV_1(DIV_1), .DIV_2(DIV_2), .DIV_3(DIV_3)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .en_i      (ctl_q.run),
        .clr_i     (clr),
        .div_sel_i (ctl_q.div_sel),
        .tick_o    (tick)
    );

    prewarn_wdog_interval #(
        .SPAN_LOG0(SPAN_LOG0), .GRACE(GRACE)
    ) u_ivl (
        .clk        (clk),
        .rst        (rst),
        .en_i       (ctl_q.run),
        .clr_i      (clr),
        .span_sel_i (ctl_q.span_sel),
        .tick_i     (tick),
        .expire_o   (expire),
        .bite_o     (bite)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            irq_flag_q <= 1'b0;
            rst_flag_q <= 1'b0;
            rst_req    <= 1'b0;
        end else begin
            if (wr_en)
                ctl_q <= ctl_w;
            // new events win over a same-cycle clear
            irq_flag_q <= (irq_flag_q && !(wr_en && wr_data[B_IRQ_FLG])) || expire;
            rst_flag_q <= (rst_flag_q && !(wr_en && wr_data[B_RST_FLG])) ||
                          (bite && ctl_q.rst_en);
            rst_req    <= bite && ctl_q.rst_en;
        end
    end

    assign rd_data = encode_word(ctl_q, irq_flag_q, rst_flag_q);
    assign irq     = irq_flag_q && ctl_q.irq_en;

    // R6: the request lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R6: the request is always accompanied by the sticky flag
    a_r6_flag_follows: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> rst_flag_q);

    // R6: no request unless reset was enabled
    a_r6_needs_enable: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(ctl_q.rst_en));

    // R3: the warning flag only rises on an interval expiry
    a_r3_flag_from_expiry: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag_q) |-> $past(expire));

    // R8: a stopped timer never expires
    a_r8_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.run |-> !expire && !bite);

endmodule

// File: tb/prewarn_wdog_bench.sv
module prewarn_wdog_bench;

    localparam int unsigned D0 = 1, D1 = 2, D2 = 4, D3 = 8;
    localparam int unsigned SL0 = 2;
    localparam int unsigned GR  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;
    logic        rst_req;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    prewarn_wdog #(
        .DIV_0(D0), .DIV_1(D1), .DIV_2(D2), .DIV_3(D3),
        .SPAN_LOG0(SL0), .GRACE(GR)
    ) u_prewarn_wdog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
    );

    function automatic int unsigned divof(input int unsigned p);
        case (p)
            0: return D0;
            1: return D1;
            2: return D2;
            default: return D3;
        endcase
    endfunction

    function automatic int unsigned tout(input int unsigned p, input int unsigned i);
        return divof(p) * (1 << (SL0 + 2 * i));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    // one write; returns at the falling edge just after the write edge
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic halt_clear();
        wr(32'h0000_000C);
    endtask

    // called right after the write: irq low until cycle n, high at n
    task automatic expect_irq_at(input string req, input int unsigned n);
        wait_n(n - 1);
        chk({req, " irq one cycle early"}, {31'b0, irq}, 32'd0);
        wait_n(1);
        chk({req, " irq at timeout"}, {31'b0, irq}, 32'd1);
    endtask

    task automatic t_reset_state();
        chk("R1 word", rd_data, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 rst_req", {31'b0, rst_req}, 32'd0);
    endtask

    task automatic t_readback();
        wr(32'hFFFF_FCF3);
        chk("R2 readback", rd_data, 32'h0000_0CF2);
        halt_clear();
        chk("R2 stopped word", rd_data, 32'h0);
    endtask

    task automatic t_timeouts();
        logic [31:0] w;
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 4; i++) begin
                if ((p + i) % 3 == 0 || (p == 3 && i == 3)) begin
                    halt_clear();
                    w = 32'h0000_00C1 | (32'(p) << 10) | (32'(i) << 4);
                    wr(w);
                    expect_irq_at("R3", tout(p, i));
                    chk("R3 flag bit", {31'b0, rd_data[3]}, 32'd1);
                end
            end
        end
        halt_clear();
    endtask

    task automatic t_irq_mask();
        wr(32'h0000_0081);  // run, codes 0, irq disabled
        wait_n(tout(0, 0) + 2);
        chk("R4 masked irq", {31'b0, irq}, 32'd0);
        chk("R4 flag set while masked", {31'b0, rd_data[3]}, 32'd1);
        wr(32'h0000_00C1);  // enable irq, keep flag
        chk("R4 irq after enable", {31'b0, irq}, 32'd1);
        wr(32'h0000_0008);  // clear flag and stop
        chk("R7 flag cleared", {31'b0, rd_data[3]}, 32'd0);
        chk("R7 irq dropped", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_ping();
        halt_clear();
        wr(32'h0000_04C1);
        wait_n(5);
        wr(32'h0000_04C1);
        expect_irq_at("R5", tout(1, 0));
        halt_clear();
    endtask

    task automatic t_bite(input logic en_rst);
        int unsigned n;
        int pulses;
        n = tout(1, 0) + GR * D1;
        halt_clear();
        wr(en_rst ? 32'h0000_04C3 : 32'h0000_04C1);
        wait_n(n - 1);
        chk("R6 no request early", {31'b0, rst_req}, 32'd0);
        wait_n(1);
        chk("R6 request at grace end", {31'b0, rst_req}, {31'b0, en_rst});
        wait_n(1);
        chk("R6 request one cycle", {31'b0, rst_req}, 32'd0);
        chk("R6 reset flag", {31'b0, rd_data[2]}, {31'b0, en_rst});
        pulses = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (rst_req) pulses++;
        end
        chk("R6 no repeat request", 32'(pulses), 32'd0);
        halt_clear();
        chk("R7 reset flag cleared", {31'b0, rd_data[2]}, 32'd0);
    endtask

    task automatic t_stop();
        wr(32'h0000_04C1);
        wait_n(3);
        wr(32'h0000_0000);
        chk("R8 running bit", {31'b0, rd_data[7]}, 32'd0);
        wait_n(300);
        chk("R8 no expiry", {31'b0, irq}, 32'd0);
        chk("R8 word", rd_data, 32'h0);
    endtask

    task automatic t_code_change();
        halt_clear();
        wr(32'h0000_04C1);
        wait_n(6);
        wr(32'h0000_04D0);  // interval 01, no restart bit
        expect_irq_at("R9 interval change", tout(1, 1));
        halt_clear();
        wr(32'h0000_04C1);
        wait_n(6);
        wr(32'h0000_08C0);  // prescaler 10, no restart bit
        expect_irq_at("R9 prescaler change", tout(2, 0));
        halt_clear();
    endtask

    task automatic t_forced();
        int unsigned n;
        int hi;
        halt_clear();
        n = tout(0, 0) + GR * D0;
        wr(32'h0000_0083);
        hi = 0;
        for (int k = 1; k < int'(n); k++) begin
            @(negedge clk);
            if (irq || rst_req) hi++;
        end
        chk("R10 quiet before request", 32'(hi), 32'd0);
        wait_n(1);
        chk("R10 forced request", {31'b0, rst_req}, 32'd1);
        chk("R10 irq low", {31'b0, irq}, 32'd0);
        halt_clear();
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_readback();
        t_timeouts();
        t_irq_mask();
        t_ping();
        t_bite(1'b1);
        t_bite(1'b0);
        t_stop();
        t_code_change();
        t_forced();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule